// File: doc/BRIEF.md
# Fall-Through Shift FIFO

This block is a first-in first-out buffer built as a linear chain of storage stages instead of a RAM with read and write pointers. Every stage holds one word and a valid flag of its own. A word written at the head of the chain moves toward the tail by itself. On each clock it steps into the next stage if that stage is empty, so stored words gather at the output end and free slots drift back toward the input end.

Both sides use a level handshake that is sampled by the system clock. On the write side, a rising shift-in request captures the input word when input-ready is high. The word is held in the head stage until the request falls. On the read side, a rising shift-out request takes the word at the tail: output-ready drops, but the data stays on the output. The word is released when the request falls, and the next stored word can then step into the tail. An active-low reset empties the whole chain.

Top module: `shift_fifo`

## Requirements
- R1: While reset is low, and on leaving it, every stage is empty: input-ready is 1, output-ready is 0 and the data output is all zeros.
- R2: Input-ready is 1 exactly when the head stage is empty. A rising shift-in request seen while input-ready is 1 captures the data input into the head stage, and input-ready goes to 0 within 8 clocks of the request rising.
- R3: A captured word stays in the head stage for as long as shift-in is held high, so an empty FIFO keeps output-ready at 0 during that time. After shift-in falls, the word reaches the output stage within DEPTH+6 clocks.
- R4: Words leave in the order they were captured, with their values unchanged.
- R5: After DEPTH words are stored with no read, input-ready stays at 0. After one word is read out, input-ready returns to 1 once the free slot has moved to the head.
- R6: A rising shift-out request seen while output-ready is 1 drives output-ready to 0 within 8 clocks. The data output does not change while the request stays high. More generally, the data output changes only when a new word enters the output stage, and that raises output-ready.
- R7: When shift-out falls, the tail word is dropped. If a valid word waits upstream, it advances into the tail and output-ready rises again.
- R8: When the FIFO is empty, output-ready stays at 0 and the data output keeps the last word that was presented.
- R9: A rising shift-in request seen while input-ready is 0 stores nothing. A rising shift-out request seen while output-ready is 0 has no effect, and a word written afterwards is presented normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples both requests |
| rstN | input | 1 | Active-low reset; empties every stage |
| shiftIn | input | 1 | Write request level |
| dataIn | input | WIDTH | Word captured on a write |
| inReady | output | 1 | Head stage empty, a write will be accepted |
| shiftOut | input | 1 | Read request level |
| outReady | output | 1 | Valid, not yet taken word at the output |
| dataOut | output | WIDTH | Word at the output stage |

## Verification
A valid flag that is set or cleared wrongly shows up at the ports within about one chain length. A lost bubble keeps input-ready low when the FIFO is not full. A stuck flag produces a duplicate or a missing word in the read stream, and the scoreboard catches it at the next read. A hold flag left set after an ignored shift-out hides the next word, so output-ready never rises within DEPTH+6 clocks. A hold flag that is cleared too early lets the head word fall through while shift-in is still high, and output-ready rises during a long write.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
  // strobes from the handshake control to the stage chain
  typedef struct packed {
    logic load;       // capture dataIn into the head stage
    logic holdFirst;  // keep the head word in place while shift-in is high
    logic drop;       // empty the tail stage
  } fifoStrobeT;
endpackage

// File: rtl/shift_fifo_edge.sv
module shift_fifo_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], level};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/shift_fifo_ctrl.sv
module shift_fifo_ctrl
  import shift_fifo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftIn,
  input  logic       shiftOut,
  input  logic       firstFull,
  input  logic       lastFull,
  output fifoStrobeT strb,
  output logic       inReady,
  output logic       outReady
);
  logic siRise, siFall, soRise, soFall;
  logic inHold, outHold;
  logic take;

  shift_fifo_edge #(.STAGES(SYNC_STAGES)) u_siEdge (
    .clk(clk), .rstN(rstN), .level(shiftIn), .rise(siRise), .fall(siFall)
  );
  shift_fifo_edge #(.STAGES(SYNC_STAGES)) u_soEdge (
    .clk(clk), .rstN(rstN), .level(shiftOut), .rise(soRise), .fall(soFall)
  );

  assign inReady  = ~firstFull;
  assign outReady = lastFull & ~outHold;
  assign take     = soRise & outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inHold  <= 1'b0;
      outHold <= 1'b0;
    end else begin
      if (siRise && inReady) inHold <= 1'b1;
      else if (siFall)       inHold <= 1'b0;
      if (take)                  outHold <= 1'b1;
      else if (soFall && outHold) outHold <= 1'b0;
    end
  end

  always_comb begin
    strb.load      = siRise & inReady;
    strb.holdFirst = inHold;
    strb.drop      = soFall & outHold;
  end
endmodule

// File: rtl/shift_fifo_chain.sv
module shift_fifo_chain
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobeT       strb,
  input  logic [WIDTH-1:0] dataIn,
  output logic             firstFull,
  output logic             lastFull,
  output logic [WIDTH-1:0] dataOut
);
  localparam int LAST = DEPTH - 1;

  logic             validQ [DEPTH];
  logic [WIDTH-1:0] dataQ  [DEPTH];
  logic [LAST-1:0]  moveV;

  // a full stage steps forward into an empty neighbour
  for (genvar i = 0; i < LAST; i++) begin : g_move
    if (i == 0) begin : g_head
      assign moveV[i] = validQ[i] & ~validQ[i+1] & ~strb.holdFirst;
    end else begin : g_body
      assign moveV[i] = validQ[i] & ~validQ[i+1];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic             fillS;
    logic             emptyS;
    logic [WIDTH-1:0] srcS;

    if (i == 0) begin : g_src0
      assign fillS = strb.load;
      assign srcS  = dataIn;
    end else begin : g_srcN
      assign fillS = moveV[i-1];
      assign srcS  = dataQ[i-1];
    end

    if (i == LAST) begin : g_sinkT
      assign emptyS = strb.drop;
    end else begin : g_sinkN
      assign emptyS = moveV[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        dataQ[i]  <= '0;
      end else if (fillS) begin
        validQ[i] <= 1'b1;
        dataQ[i]  <= srcS;
      end else if (emptyS) begin
        validQ[i] <= 1'b0;
      end
    end
  end

  assign firstFull = validQ[0];
  assign lastFull  = validQ[LAST];
  assign dataOut   = dataQ[LAST];
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic             outReady,
  output logic [WIDTH-1:0] dataOut
);
  fifoStrobeT strb;
  logic       firstFull;
  logic       lastFull;

  shift_fifo_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .firstFull(firstFull), .lastFull(lastFull), .strb(strb),
    .inReady(inReady), .outReady(outReady)
  );

  shift_fifo_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .firstFull(firstFull), .lastFull(lastFull), .dataOut(dataOut)
  );
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             outReady,
  input logic [WIDTH-1:0] dataOut,
  input logic             load,
  input logic             drop
);
  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] occ;
  logic          rstPrevLow = 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else       occ <= occ + CW'(load) - CW'(drop);
  end

  always @(posedge clk) begin
    if (!rstN && rstPrevLow)
      AST_RESET_STATE: assert (!outReady && inReady) else $error("reset state wrong"); // R1
    rstPrevLow <= !rstN;
  end

  AST_LOAD_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !inReady) else $error("input ready after load"); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CW'(DEPTH)) else $error("occupancy above depth"); // R5

  AST_FULL_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CW'(DEPTH)) |-> !inReady) else $error("input ready while full"); // R5

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !outReady) else $error("output ready while empty"); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> outReady) else $error("output changed without new word"); // R6

  AST_DROP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    drop |-> !outReady) else $error("drop of untaken word"); // R7
endmodule

bind shift_fifo shift_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outReady(outReady),
  .dataOut(dataOut), .load(strb.load), .drop(strb.drop)
);

// File: tb/test_shift_fifo.sv
`timescale 1ns/1ps
module test_shift_fifo;
  localparam int DEPTH = 64;
  localparam int WIDTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftIn = 1'b0;
  logic shiftOut = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic inReady, outReady;
  logic [WIDTH-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [WIDTH-1:0] expQ[$];

  always #4 clk = ~clk;

  shift_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_shift_fifo (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outReady(outReady), .dataOut(dataOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: writes one word and records it in the scoreboard
  task automatic pushWord(input logic [WIDTH-1:0] d, input int holdCyc);
    int n = 0;
    while (!inReady && n < 4*DEPTH) begin @(negedge clk); n++; end
    check(inReady, "R2 input ready before write", int'(inReady), 1);
    dataIn = d;
    shiftIn = 1'b1;
    expQ.push_back(d);
    n = 0;
    while (inReady && n < 8) begin @(negedge clk); n++; end
    check(!inReady, "R2 input ready drops after capture", int'(inReady), 0);
    cycles(holdCyc);
    shiftIn = 1'b0;
    cycles(4);
  endtask

  // monitor: takes one word and compares it with the scoreboard
  task automatic popWord();
    int n = 0;
    logic [WIDTH-1:0] exp, seen;
    while (!outReady && n < 2*DEPTH + 16) begin @(negedge clk); n++; end
    check(outReady, "R7 output ready rises with next word", int'(outReady), 1);
    if (expQ.size() == 0) begin
      check(1'b0, "R9 unexpected stored word", int'(dataOut), -1);
      exp = dataOut;
    end else exp = expQ.pop_front();
    check(dataOut == exp, "R4 output word order", int'(dataOut), int'(exp));
    seen = dataOut;
    shiftOut = 1'b1;
    n = 0;
    while (outReady && n < 8) begin @(negedge clk); n++; end
    check(!outReady, "R6 output ready drops on shift-out", int'(outReady), 0);
    cycles(5);
    check(dataOut == seen, "R6 data held during shift-out", int'(dataOut), int'(seen));
    shiftOut = 1'b0;
    cycles(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int n;
    bit sawOut;
    cycles(3);
    check(inReady == 1'b1, "R1 input ready in reset", int'(inReady), 1);
    check(outReady == 1'b0, "R1 output ready in reset", int'(outReady), 0);
    check(dataOut == '0, "R1 data output in reset", int'(dataOut), 0);
    rstN = 1'b1;
    cycles(2);

    // R3: long write holds the word at the head
    dataIn = 4'hA;
    shiftIn = 1'b1;
    expQ.push_back(4'hA);
    n = 0;
    while (inReady && n < 8) begin @(negedge clk); n++; end
    check(!inReady, "R2 capture on empty fifo", int'(inReady), 0);
    sawOut = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (outReady) sawOut = 1;
    end
    check(!sawOut, "R3 word held while shift-in high", int'(sawOut), 0);
    shiftIn = 1'b0;
    n = 0;
    while (!outReady && n < 2*DEPTH) begin @(negedge clk); n++; end
    check(n <= DEPTH + 6, "R3 fall-through latency", n, DEPTH + 6);
    popWord();

    // R8: empty keeps last word
    cycles(80);
    check(!outReady, "R8 output ready low when empty", int'(outReady), 0);
    check(dataOut == 4'hA, "R8 output keeps last word", int'(dataOut), 10);

    // R9: shift-out while nothing is ready
    shiftOut = 1'b1;
    cycles(10);
    check(!outReady, "R9 ignored shift-out keeps ready low", int'(outReady), 0);
    check(dataOut == 4'hA, "R9 ignored shift-out keeps data", int'(dataOut), 10);
    shiftOut = 1'b0;
    cycles(5);
    pushWord(4'h5, 3);
    popWord();

    // R5: fill to capacity
    for (int k = 0; k < DEPTH; k++) pushWord(WIDTH'(k*3 + 1), 2);
    cycles(DEPTH + 10);
    check(!inReady, "R5 input ready low when full", int'(inReady), 0);
    dataIn = 4'hF;
    shiftIn = 1'b1;
    cycles(10);
    shiftIn = 1'b0;
    cycles(5);
    check(!inReady, "R9 write while full ignored", int'(inReady), 0);
    popWord();
    n = 0;
    while (!inReady && n < 2*DEPTH + 16) begin @(negedge clk); n++; end
    check(inReady, "R5 input ready returns after a read", int'(inReady), 1);
    for (int k = 1; k < DEPTH; k++) popWord();
    cycles(DEPTH + 20);
    check(!outReady, "R9 no extra word stored when full", int'(outReady), 0);
    check(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);

    // R4/R7: concurrent traffic
    fork
      begin
        for (int k = 0; k < 40; k++) pushWord(WIDTH'(k ^ 9), 1);
      end
      begin
        for (int k = 0; k < 40; k++) popWord();
      end
    join

    // R1: reset in the middle of traffic
    for (int k = 0; k < 5; k++) pushWord(WIDTH'(k + 2), 1);
    rstN = 1'b0;
    cycles(2);
    check(!outReady, "R1 output ready after mid reset", int'(outReady), 0);
    check(inReady, "R1 input ready after mid reset", int'(inReady), 1);
    expQ.delete();
    rstN = 1'b1;
    cycles(2);
    pushWord(4'hC, 2);
    popWord();

    finishRun();
  end
endmodule